// File: doc/BRIEF.md
# Sideband Mailbox Target Register Bank

This block is the target-side register file of a sideband management link. A remote host reaches it through a simple byte-wide register bus. To pass a command to local firmware, the host first loads a command byte and a 32-bit argument into a bank of inbound message bytes. It then marks the command as waiting and rings a software-interrupt register. The block takes a snapshot of the command and the argument and presents it on a request/response port toward the firmware side. It holds that request until the firmware answers.

The answer carries 32 bits of result data and an error byte. The block stores them in a bank of outbound message bytes. An error byte of zero means success and the data is kept. A nonzero error byte replaces the data, and the result bytes read back as zero. Completion sets a sticky alert bit in the status register. The host clears that bit by writing a one to it. The alert pin follows the alert bit, gated by an enable bit in the control register. The serial transport and the firmware are outside the block.

Top module: `sbmbx_target`

## Requirements
- R1: After reset every register reads 0x00, `fw_req_valid` is low and `alert_o` is low.
- R2: The inbound bytes at 0x38..0x3F are read/write. 0x38 is the command byte. 0x39 (least significant) to 0x3C (most significant) form the 32-bit argument. Bit 7 of 0x3F is the command-waiting mark, set by writing 0x80.
- R3: A write with bit 0 set to the interrupt register at 0x40 starts a command when no command is outstanding and the waiting mark is set. `fw_req_valid` rises on the next cycle, with `fw_req_cmd` and `fw_req_data` holding a snapshot of 0x38 and 0x39..0x3C. The request stays valid and unchanged until `fw_rsp_valid`.
- R4: Bit 0 of 0x40 reads 1 while a command is outstanding and clears by itself on completion. A trigger write while a command is outstanding is ignored and the request is unchanged. A trigger write while the waiting mark is clear starts nothing.
- R5: A response (`fw_rsp_valid` while a command is outstanding) sets status bit 1 at 0x02, clears 0x3F to 0x00 and ends the command in that same cycle.
- R6: With a zero error byte, the response data reads back at 0x31 (least significant) to 0x34 (most significant) and 0x37 reads 0x00. With a nonzero error byte, 0x37 holds it and 0x31..0x34 read 0x00.
- R7: Writing 0x02 to 0x02 clears status bit 1, and writing 0 to that bit has no effect. When a response and a clearing write fall in the same cycle, the bit stays set.
- R8: `alert_o` is high exactly when status bit 1 is set and the enable, bit 0 of the control register at 0x01, is set.
- R9: Unmapped addresses read 0x00 and ignore writes. The outbound bytes 0x30..0x37 ignore host writes, and 0x30, 0x35 and 0x36 read 0x00. A response while no command is outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host register byte address |
| host_wen | input | 1 | Host write strobe for one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| fw_req_valid | output | 1 | Command outstanding toward firmware |
| fw_req_cmd | output | 8 | Command byte snapshot |
| fw_req_data | output | 32 | Argument snapshot |
| fw_rsp_valid | input | 1 | Firmware response strobe |
| fw_rsp_data | input | 32 | Firmware result data |
| fw_rsp_err | input | 8 | Firmware error code, zero for success |
| alert_o | output | 1 | Alert pin toward the host |

## Verification
Two actions can land on status bit 1 in the same cycle: a firmware completion that sets it and a host write-one that clears it. The bench first leaves the bit set from an earlier command and issues a second command. It then drives `fw_rsp_valid` and a clearing write of 0x02 on the same clock edge. Afterwards, both the status register and `alert_o` must show the bit still set. A clearing write in a later cycle must then take it to zero.

// File: rtl/sbmbx_pkg.sv
package sbmbx_pkg;
  localparam int MB_BYTES = 4;
  localparam int MB_W     = MB_BYTES * 8;
  localparam int BANK_N   = 8;

  localparam logic [7:0] A_CTRL    = 8'h01;
  localparam logic [7:0] A_STAT    = 8'h02;
  localparam logic [7:0] A_SWI     = 8'h40;
  localparam logic [4:0] A_OUT_HI  = 5'h06;   // 0x30..0x37
  localparam logic [4:0] A_IN_HI   = 5'h07;   // 0x38..0x3F
  localparam int         ERR_SLOT  = 7;

  // Outbound byte view: slots 1..MB_BYTES carry result bytes, slot 7 the error.
  function automatic logic [7:0] out_byte(input logic [MB_W-1:0] data,
                                          input logic [7:0] err,
                                          input logic [2:0] idx);
    logic [7:0] r;
    r = 8'h00;
    for (int b = 0; b < MB_BYTES; b++)
      if (int'(idx) == b + 1) r = data[b*8 +: 8];
    if (int'(idx) == ERR_SLOT) r = err;
    return r;
  endfunction
endpackage

// File: rtl/sbmbx_inbound.sv
module sbmbx_inbound
  import sbmbx_pkg::*;
#(
  parameter int DATA_BYTES = MB_BYTES,
  localparam int DW = DATA_BYTES * 8,
  localparam int IW = $clog2(BANK_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wr_data,
  input  logic          clr_mark,
  output logic [7:0]    rd_data,
  output logic          mark_set,
  output logic [7:0]    cmd,
  output logic [DW-1:0] arg
);
  logic [7:0] bank [BANK_N];

  for (genvar g = 0; g < BANK_N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[g] <= 8'h00;
      else if (wr_en && idx == IW'(g))
        bank[g] <= wr_data;
      else if (g == BANK_N - 1 && clr_mark)
        bank[g] <= 8'h00;
    end
  end

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_arg
    assign arg[b*8 +: 8] = bank[b+1];
  end

  assign cmd      = bank[0];
  assign mark_set = bank[BANK_N-1][7];
  assign rd_data  = bank[idx];

  // R5
  mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_mark && !wr_en |=> !mark_set);
endmodule

// File: rtl/sbmbx_fw_port.sv
module sbmbx_fw_port
  import sbmbx_pkg::*;
#(
  parameter int DATA_BYTES = MB_BYTES,
  localparam int DW = DATA_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_wr,
  input  logic          in_mark,
  input  logic [7:0]    in_cmd,
  input  logic [DW-1:0] in_arg,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic [7:0]    rsp_err,
  input  logic [2:0]    out_idx,
  output logic [7:0]    out_rd,
  output logic          req_valid,
  output logic [7:0]    req_cmd,
  output logic [DW-1:0] req_arg,
  output logic          done
);
  logic          pending;
  logic          fire;
  logic [DW-1:0] res_data;
  logic [7:0]    res_err;

  assign fire = trig_wr && in_mark && !pending;
  assign done = pending && rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      req_cmd <= 8'h00;
      req_arg <= '0;
    end else if (fire) begin
      pending <= 1'b1;
      req_cmd <= in_cmd;
      req_arg <= in_arg;
    end else if (done) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data <= '0;
      res_err  <= 8'h00;
    end else if (done) begin
      res_err  <= rsp_err;
      res_data <= (rsp_err == 8'h00) ? rsp_data : '0;
    end
  end

  assign req_valid = pending;
  assign out_rd    = out_byte(res_data, res_err, out_idx);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_valid |=> req_valid && $stable(req_cmd) && $stable(req_arg));
  // R4
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(trig_wr) && $past(in_mark));
  // R6
  err_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && rsp_err != 8'h00 |=> res_data == '0 && res_err == $past(rsp_err));
  // R9
  idle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending && !fire |=> $stable(res_data) && $stable(res_err));
endmodule

// File: rtl/sbmbx_status.sv
module sbmbx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_evt,
  input  logic       stat_wr,
  input  logic       stat_w1c,
  input  logic       ctrl_wr,
  input  logic       ctrl_en_in,
  output logic [7:0] stat_byte,
  output logic [7:0] ctrl_byte,
  output logic       alert_o
);
  logic sw_alert;
  logic alert_en;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sw_alert <= 1'b0;
    else if (set_evt)
      sw_alert <= 1'b1;
    else if (stat_wr && stat_w1c)
      sw_alert <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      alert_en <= 1'b0;
    else if (ctrl_wr)
      alert_en <= ctrl_en_in;
  end

  assign stat_byte = {6'b0, sw_alert, 1'b0};
  assign ctrl_byte = {7'b0, alert_en};
  assign alert_o   = sw_alert && alert_en;

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> sw_alert);
  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && stat_w1c && !set_evt |=> !sw_alert);
  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_alert && !(stat_wr && stat_w1c) |=> sw_alert);
endmodule

// File: rtl/sbmbx_target.sv
module sbmbx_target
  import sbmbx_pkg::*;
#(
  parameter int DATA_BYTES = MB_BYTES,
  localparam int DW = DATA_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    host_addr,
  input  logic          host_wen,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          fw_req_valid,
  output logic [7:0]    fw_req_cmd,
  output logic [DW-1:0] fw_req_data,
  input  logic          fw_rsp_valid,
  input  logic [DW-1:0] fw_rsp_data,
  input  logic [7:0]    fw_rsp_err,
  output logic          alert_o
);
  logic          hit_in, hit_out, hit_ctrl, hit_stat, hit_swi;
  logic [7:0]    in_rd, out_rd, stat_byte, ctrl_byte;
  logic          in_mark, done;
  logic [7:0]    in_cmd;
  logic [DW-1:0] in_arg;

  assign hit_in   = host_addr[7:3] == A_IN_HI;
  assign hit_out  = host_addr[7:3] == A_OUT_HI;
  assign hit_ctrl = host_addr == A_CTRL;
  assign hit_stat = host_addr == A_STAT;
  assign hit_swi  = host_addr == A_SWI;

  sbmbx_inbound #(.DATA_BYTES(DATA_BYTES)) u_in (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wen && hit_in), .idx(host_addr[2:0]), .wr_data(host_wdata),
    .clr_mark(done), .rd_data(in_rd), .mark_set(in_mark),
    .cmd(in_cmd), .arg(in_arg)
  );

  sbmbx_fw_port #(.DATA_BYTES(DATA_BYTES)) u_fw (
    .clk(clk), .rst_n(rst_n),
    .trig_wr(host_wen && hit_swi && host_wdata[0]),
    .in_mark(in_mark), .in_cmd(in_cmd), .in_arg(in_arg),
    .rsp_valid(fw_rsp_valid), .rsp_data(fw_rsp_data), .rsp_err(fw_rsp_err),
    .out_idx(host_addr[2:0]), .out_rd(out_rd),
    .req_valid(fw_req_valid), .req_cmd(fw_req_cmd), .req_arg(fw_req_data),
    .done(done)
  );

  sbmbx_status u_st (
    .clk(clk), .rst_n(rst_n),
    .set_evt(done),
    .stat_wr(host_wen && hit_stat), .stat_w1c(host_wdata[1]),
    .ctrl_wr(host_wen && hit_ctrl), .ctrl_en_in(host_wdata[0]),
    .stat_byte(stat_byte), .ctrl_byte(ctrl_byte), .alert_o(alert_o)
  );

  always_comb begin
    host_rdata = 8'h00;
    if (hit_in)        host_rdata = in_rd;
    else if (hit_out)  host_rdata = out_rd;
    else if (hit_ctrl) host_rdata = ctrl_byte;
    else if (hit_stat) host_rdata = stat_byte;
    else if (hit_swi)  host_rdata = {7'b0, fw_req_valid};
  end

  // R8
  alert_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_o |-> ctrl_byte[0] && stat_byte[1]);
  // R5
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fw_req_valid && fw_rsp_valid |=> !fw_req_valid);
endmodule

// File: tb/sbmbx_target_tb_top.sv
module sbmbx_target_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic        host_wen = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        fw_req_valid;
  logic [7:0]  fw_req_cmd;
  logic [31:0] fw_req_data;
  logic        fw_rsp_valid = 1'b0;
  logic [31:0] fw_rsp_data = 32'h0;
  logic [7:0]  fw_rsp_err = 8'h00;
  logic        alert_o;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sbmbx_target dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wen(host_wen),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fw_req_valid(fw_req_valid), .fw_req_cmd(fw_req_cmd), .fw_req_data(fw_req_data),
    .fw_rsp_valid(fw_rsp_valid), .fw_rsp_data(fw_rsp_data), .fw_rsp_err(fw_rsp_err),
    .alert_o(alert_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wen = 1'b1;
    @(posedge clk); #1;
    host_wen = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    host_addr = a;
    #1 check(tag, {24'h0, host_rdata}, {24'h0, exp});
  endtask

  task automatic load_cmd(input logic [7:0] c, input logic [31:0] d);
    wr(8'h38, c);
    for (int i = 0; i < 4; i++) wr(8'h39 + 8'(i), d[i*8 +: 8]);
    wr(8'h3F, 8'h80);
  endtask

  task automatic fw_reply(input logic [31:0] d, input logic [7:0] e);
    @(negedge clk);
    fw_rsp_valid = 1'b1; fw_rsp_data = d; fw_rsp_err = e;
    @(posedge clk); #1;
    fw_rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    rd("R1 ctrl", 8'h01, 8'h00);
    rd("R1 stat", 8'h02, 8'h00);
    rd("R1 swi", 8'h40, 8'h00);
    rd("R1 in0", 8'h38, 8'h00);
    rd("R1 in7", 8'h3F, 8'h00);
    rd("R1 out7", 8'h37, 8'h00);
    check("R1 req_valid", {31'h0, fw_req_valid}, 32'h0);
    check("R1 alert", {31'h0, alert_o}, 32'h0);
  endtask

  task automatic t_inbound_rw;
    for (int i = 0; i < 8; i++) wr(8'h38 + 8'(i), 8'hA0 + 8'(i));
    for (int i = 0; i < 7; i++) rd("R2 inbound rw", 8'h38 + 8'(i), 8'hA0 + 8'(i));
    wr(8'h3F, 8'h00);
    rd("R2 in7 rw", 8'h3F, 8'h00);
  endtask

  task automatic t_basic;
    wr(8'h01, 8'h01);
    load_cmd(8'h5A, 32'h11223344);
    wr(8'h40, 8'h01);
    @(negedge clk);
    check("R3 req_valid", {31'h0, fw_req_valid}, 32'h1);
    check("R3 req_cmd", {24'h0, fw_req_cmd}, 32'h5A);
    check("R3 req_data", fw_req_data, 32'h11223344);
    rd("R4 swi busy", 8'h40, 8'h01);
    wr(8'h38, 8'h66);
    wr(8'h39, 8'h99);
    wr(8'h40, 8'h01);
    @(negedge clk);
    check("R4 retrig cmd", {24'h0, fw_req_cmd}, 32'h5A);
    check("R4 retrig data", fw_req_data, 32'h11223344);
    check("R3 still valid", {31'h0, fw_req_valid}, 32'h1);
    fw_reply(32'hCAFEF00D, 8'h00);
    rd("R6 out1", 8'h31, 8'h0D);
    rd("R6 out2", 8'h32, 8'hF0);
    rd("R6 out3", 8'h33, 8'hFE);
    rd("R6 out4", 8'h34, 8'hCA);
    rd("R6 out7", 8'h37, 8'h00);
    rd("R5 stat", 8'h02, 8'h02);
    rd("R5 in7 cleared", 8'h3F, 8'h00);
    rd("R4 swi selfclear", 8'h40, 8'h00);
    check("R5 req done", {31'h0, fw_req_valid}, 32'h0);
    check("R8 alert on", {31'h0, alert_o}, 32'h1);
  endtask

  task automatic t_w1c;
    wr(8'h02, 8'h00);
    rd("R7 write0 keeps", 8'h02, 8'h02);
    wr(8'h02, 8'h02);
    rd("R7 w1c", 8'h02, 8'h00);
    check("R8 alert off", {31'h0, alert_o}, 32'h0);
  endtask

  task automatic t_enable;
    wr(8'h01, 8'h00);
    load_cmd(8'h10, 32'h0);
    wr(8'h40, 8'h01);
    fw_reply(32'h00000001, 8'h00);
    rd("R8 stat set", 8'h02, 8'h02);
    check("R8 masked", {31'h0, alert_o}, 32'h0);
    wr(8'h01, 8'h01);
    @(negedge clk);
    check("R8 unmasked", {31'h0, alert_o}, 32'h1);
    wr(8'h02, 8'h02);
  endtask

  task automatic t_error;
    load_cmd(8'h21, 32'hDEADBEEF);
    wr(8'h40, 8'h01);
    fw_reply(32'h12345678, 8'h07);
    rd("R6 err out1", 8'h31, 8'h00);
    rd("R6 err out4", 8'h34, 8'h00);
    rd("R6 err code", 8'h37, 8'h07);
    rd("R5 err stat", 8'h02, 8'h02);
    wr(8'h02, 8'h02);
  endtask

  task automatic t_nomark;
    wr(8'h3F, 8'h00);
    wr(8'h40, 8'h01);
    @(negedge clk);
    check("R4 no mark", {31'h0, fw_req_valid}, 32'h0);
    rd("R4 no mark swi", 8'h40, 8'h00);
  endtask

  task automatic t_unmapped;
    wr(8'h77, 8'hFF);
    rd("R9 unmapped", 8'h77, 8'h00);
    rd("R9 out0", 8'h30, 8'h00);
    rd("R9 out5", 8'h35, 8'h00);
    wr(8'h37, 8'h55);
    rd("R9 out ro", 8'h37, 8'h07);
    fw_reply(32'hFFFFFFFF, 8'h00);
    rd("R9 idle rsp stat", 8'h02, 8'h00);
    rd("R9 idle rsp out7", 8'h37, 8'h07);
    rd("R9 idle rsp out1", 8'h31, 8'h00);
  endtask

  task automatic t_collide;
    load_cmd(8'h30, 32'h1);
    wr(8'h40, 8'h01);
    fw_reply(32'hAAAA5555, 8'h00);
    load_cmd(8'h31, 32'h2);
    wr(8'h40, 8'h01);
    @(negedge clk);
    fw_rsp_valid = 1'b1; fw_rsp_data = 32'h01020304; fw_rsp_err = 8'h00;
    host_addr = 8'h02; host_wdata = 8'h02; host_wen = 1'b1;
    @(posedge clk); #1;
    fw_rsp_valid = 1'b0; host_wen = 1'b0;
    rd("R7 set wins", 8'h02, 8'h02);
    check("R7 alert kept", {31'h0, alert_o}, 32'h1);
    rd("R6 collide out1", 8'h31, 8'h04);
    wr(8'h02, 8'h02);
    rd("R7 later clear", 8'h02, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_inbound_rw;
    t_basic;
    t_w1c;
    t_enable;
    t_error;
    t_nomark;
    t_unmapped;
    t_collide;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule